// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits next to a single processor's memory port and arbitrates atomic read-modify-write sequences built from a load-linked followed by a store-conditional. On a load-linked it remembers the cache line that was read and arms a link flag. A plain store by the processor, a snooped invalidate or write from another agent, an exception or context switch, or the store-conditional itself can each break that link. When a store-conditional arrives, the block decides in the same cycle whether memory may be written. It reports pass or fail so that software can retry.

The processor presents at most one of three request strobes per cycle, together with an address. The snoop stream carries one invalidate or write address per cycle. The store-enable to memory and the pass flag are combinational in the request cycle. Link state changes at the following rising clock edge.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A load-linked (`opLoadLink`=1) arms the link and records the line of `reqAddr`. A store-conditional to that line in a later cycle drives `memWrEn`=1 and `scPass`=1 in its own cycle.
- R2: A store-conditional while the link is clear drives `memWrEn`=0 and `scPass`=0.
- R3: Every store-conditional clears the link, whether it passes or fails, so a second store-conditional right after a pass fails.
- R4: A snoop (`snoopValid`=1) to the reserved line clears the link. A snoop to any other line leaves it armed.
- R5: Addresses are compared as lines, using bits [ADDR_W-1:LINE_OFS_W] (bits [15:4] by default). The low offset bits are ignored.
- R6: A new load-linked replaces the older reservation, so a store-conditional to the older line fails.
- R7: A store-conditional to a line other than the reserved one fails and clears the link.
- R8: `flushReq`=1 (exception or context switch) clears the link. It wins over a load-linked in the same cycle.
- R9: A snoop to the reserved line in the same cycle as a store-conditional to that line makes the store-conditional fail.
- R10: A plain store (`opStore`=1) always drives `memWrEn`=1 and `scPass`=0. It clears the link only when it targets the reserved line.
- R11: After reset (`rstN`=0) the link is clear, so a store-conditional fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opLoadLink | input | 1 | Processor load-linked request |
| opStoreCond | input | 1 | Processor store-conditional request |
| opStore | input | 1 | Processor plain store request |
| reqAddr | input | ADDR_W | Byte address of the processor request |
| snoopValid | input | 1 | Another agent invalidates or writes a line this cycle |
| snoopAddr | input | ADDR_W | Byte address of the snooped event |
| flushReq | input | 1 | Exception or context switch; drops the reservation |
| memWrEn | output | 1 | Store enable to memory for this cycle's store |
| scPass | output | 1 | Store-conditional succeeded this cycle |

## Verification
The assertions assume that the processor raises at most one of its three request strobes in any cycle. They also assume that each strobe lasts exactly one cycle per request, so a strobe held high counts as a new request on every edge. The stimulus drives every request as a single-cycle pulse from a table entry that sets one strobe or none. It raises the snoop and flush inputs only on their own or beside one request, and never sets two request strobes in the same entry.

// File: rtl/llsc_resv_pkg.sv
package llsc_resv_pkg;
  // Strobes sent from the decision logic to the reservation state
  typedef struct packed {
    logic captureAddr; // latch the request line as the reserved line
    logic setLink;     // arm the link flag
    logic clrLink;     // drop the link flag
  } resvStrobe_t;
endpackage

// File: rtl/llsc_resv_datapath.sv
module llsc_resv_datapath
  import llsc_resv_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_OFS_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  resvStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              linkBit,
  output logic              reqHit,
  output logic              snoopHitResv,
  output logic              snoopHitReq
);
  localparam int LINE_W = ADDR_W - LINE_OFS_W;

  logic [LINE_W-1:0] resvLine;
  logic [LINE_W-1:0] reqLine;
  logic [LINE_W-1:0] snoopLine;

  assign reqLine   = reqAddr[ADDR_W-1:LINE_OFS_W];
  assign snoopLine = snoopAddr[ADDR_W-1:LINE_OFS_W];

  assign reqHit       = (reqLine == resvLine);
  assign snoopHitResv = snoopValid && (snoopLine == resvLine);
  assign snoopHitReq  = snoopValid && (snoopLine == reqLine);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resvLine <= '0;
      linkBit  <= 1'b0;
    end else begin
      if (strobe.captureAddr) resvLine <= reqLine;
      if (strobe.setLink)      linkBit <= 1'b1;
      else if (strobe.clrLink) linkBit <= 1'b0;
    end
  end

  // R5: the stored line is the line part of the captured request address
  p_capture_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureAddr |=> resvLine == $past(reqLine));
endmodule

// File: rtl/llsc_resv_control.sv
module llsc_resv_control
  import llsc_resv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opLoadLink,
  input  logic        opStoreCond,
  input  logic        opStore,
  input  logic        flushReq,
  input  logic        linkBit,
  input  logic        reqHit,
  input  logic        snoopHitResv,
  input  logic        snoopHitReq,
  output resvStrobe_t strobe,
  output logic        memWrEn,
  output logic        scPass
);
  logic breakLink;

  // Any event that could change the reserved line, or end the sequence
  assign breakLink = flushReq || opStoreCond || snoopHitResv
                   || (opStore && reqHit) || (opLoadLink && snoopHitReq);

  always_comb begin
    strobe.captureAddr = opLoadLink && !flushReq;
    strobe.setLink     = opLoadLink && !flushReq && !snoopHitReq;
    strobe.clrLink     = breakLink;
  end

  // Snoop and flush take priority over a store-conditional in the same cycle
  assign scPass  = opStoreCond && linkBit && reqHit && !snoopHitResv && !flushReq;
  assign memWrEn = opStore || scPass;

  // Input rule: at most one processor request per cycle
  p_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opLoadLink, opStoreCond, opStore}));

  p_ll_arms_r1: assert property (@(posedge clk) disable iff (!rstN)
    opLoadLink && !flushReq && !snoopHitReq |=> linkBit);

  p_sc_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    opStoreCond |=> !linkBit);

  p_snoop_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    snoopHitResv && !opLoadLink |=> !linkBit);

  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !linkBit);

  p_store_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    opStore && reqHit |=> !linkBit);
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import llsc_resv_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_OFS_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opLoadLink,
  input  logic              opStoreCond,
  input  logic              opStore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              flushReq,
  output logic              memWrEn,
  output logic              scPass
);
  resvStrobe_t strobe;
  logic linkBit, reqHit, snoopHitResv, snoopHitReq;

  llsc_resv_datapath #(.ADDR_W(ADDR_W), .LINE_OFS_W(LINE_OFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr), .linkBit(linkBit),
    .reqHit(reqHit), .snoopHitResv(snoopHitResv), .snoopHitReq(snoopHitReq)
  );

  llsc_resv_control u_ctl (
    .clk(clk), .rstN(rstN), .opLoadLink(opLoadLink), .opStoreCond(opStoreCond),
    .opStore(opStore), .flushReq(flushReq), .linkBit(linkBit), .reqHit(reqHit),
    .snoopHitResv(snoopHitResv), .snoopHitReq(snoopHitReq), .strobe(strobe),
    .memWrEn(memWrEn), .scPass(scPass)
  );
endmodule

// File: tb/test_llsc_resv_monitor.sv
`timescale 1ns/1ps
module test_llsc_resv_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opLoadLink = 1'b0, opStoreCond = 1'b0, opStore = 1'b0;
  logic snoopValid = 1'b0, flushReq = 1'b0;
  logic [15:0] reqAddr = '0, snoopAddr = '0;
  logic memWrEn, scPass;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk; // 200 MHz

  llsc_resv_monitor i_llsc_resv_monitor (
    .clk(clk), .rstN(rstN), .opLoadLink(opLoadLink), .opStoreCond(opStoreCond),
    .opStore(opStore), .reqAddr(reqAddr), .snoopValid(snoopValid),
    .snoopAddr(snoopAddr), .flushReq(flushReq), .memWrEn(memWrEn), .scPass(scPass)
  );

  // Entry: {ll,sc,st,flush,snoop}[42:38] reqAddr[37:22] snoopAddr[21:6]
  //        expWr,expPass[5:4] requirement number[3:0]
  localparam int N = 27;
  localparam logic [42:0] VEC [0:N-1] = '{
    {5'b01000, 16'h1230, 16'h0000, 2'b00, 4'd11}, // R11 SC with no link
    {5'b10000, 16'h1230, 16'h0000, 2'b00, 4'd1},  // R1 LL
    {5'b01000, 16'h1238, 16'h0000, 2'b11, 4'd5},  // R5 same line, other offset
    {5'b01000, 16'h1230, 16'h0000, 2'b00, 4'd3},  // R3 second SC fails
    {5'b10000, 16'h2000, 16'h0000, 2'b00, 4'd4},  // R4 LL
    {5'b00001, 16'h0000, 16'h3000, 2'b00, 4'd4},  // R4 snoop other line
    {5'b01000, 16'h200F, 16'h0000, 2'b11, 4'd4},  // R4 link kept
    {5'b10000, 16'h2000, 16'h0000, 2'b00, 4'd4},  // R4 LL
    {5'b00001, 16'h0000, 16'h2004, 2'b00, 4'd4},  // R4 snoop reserved line
    {5'b01000, 16'h2000, 16'h0000, 2'b00, 4'd4},  // R4 SC fails
    {5'b10000, 16'h4000, 16'h0000, 2'b00, 4'd6},  // R6 LL old
    {5'b10000, 16'h5000, 16'h0000, 2'b00, 4'd6},  // R6 LL new
    {5'b01000, 16'h4000, 16'h0000, 2'b00, 4'd6},  // R6 SC to old fails
    {5'b10000, 16'h5000, 16'h0000, 2'b00, 4'd7},  // R7 LL
    {5'b01000, 16'h5010, 16'h0000, 2'b00, 4'd7},  // R7 SC other line fails
    {5'b01000, 16'h5000, 16'h0000, 2'b00, 4'd7},  // R7 link was cleared
    {5'b10000, 16'h6000, 16'h0000, 2'b00, 4'd8},  // R8 LL
    {5'b00010, 16'h0000, 16'h0000, 2'b00, 4'd8},  // R8 flush
    {5'b01000, 16'h6000, 16'h0000, 2'b00, 4'd8},  // R8 SC fails
    {5'b10000, 16'h7000, 16'h0000, 2'b00, 4'd9},  // R9 LL
    {5'b01001, 16'h7000, 16'h7008, 2'b00, 4'd9},  // R9 SC loses to snoop
    {5'b10000, 16'h7000, 16'h0000, 2'b00, 4'd10}, // R10 LL
    {5'b00100, 16'h8000, 16'h0000, 2'b10, 4'd10}, // R10 store other line
    {5'b01000, 16'h7000, 16'h0000, 2'b11, 4'd10}, // R10 link kept
    {5'b10000, 16'h9000, 16'h0000, 2'b00, 4'd10}, // R10 LL
    {5'b00100, 16'h9004, 16'h0000, 2'b10, 4'd10}, // R10 store to reserved line
    {5'b01000, 16'h9000, 16'h0000, 2'b00, 4'd10}  // R10 SC fails
  };

  task automatic check(input logic expWr, input logic expPass, input int req);
    total++;
    if (memWrEn !== expWr || scPass !== expPass) begin
      bad++;
      $display("FAIL R%0d: memWrEn/scPass actual=%b%b expected=%b%b",
               req, memWrEn, scPass, expWr, expPass);
    end
  endtask

  task automatic drive(input logic [4:0] ops, input logic [15:0] ra,
                       input logic [15:0] sa);
    @(negedge clk);
    {opLoadLink, opStoreCond, opStore, flushReq, snoopValid} = ops;
    reqAddr = ra;
    snoopAddr = sa;
    #1;
  endtask

  task automatic idle();
    drive(5'b00000, 16'h0, 16'h0);
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(1'b0, 1'b0, 11); // R11 idle outputs after reset

    for (int i = 0; i < N; i++) begin
      drive(VEC[i][42:38], VEC[i][37:22], VEC[i][21:6]);
      check(VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
    end

    // R8: flush in the same cycle as a load-linked wins
    drive(5'b10010, 16'hA000, 16'h0);
    drive(5'b01000, 16'hA000, 16'h0);
    check(1'b0, 1'b0, 8);

    // R2: a store-conditional long after an idle stretch with no link
    idle(); idle();
    drive(5'b01000, 16'hA000, 16'h0);
    check(1'b0, 1'b0, 2);

    // R1: the link survives idle cycles
    drive(5'b10000, 16'hC000, 16'h0);
    idle(); idle(); idle();
    drive(5'b01000, 16'hC00C, 16'h0);
    check(1'b1, 1'b1, 1);

    // R11: a reset in the middle of a sequence drops the reservation
    drive(5'b10000, 16'hB000, 16'h0);
    idle();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    drive(5'b01000, 16'hB000, 16'h0);
    check(1'b0, 1'b0, 11);
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule